// File: doc/BRIEF.md
# DMA Page Register Alias Decoder

This block sits on the I/O decode path of a system bridge and handles every I/O access that lands in the window from 80h to 9Fh. It holds a bank of sixteen 8-bit page registers at 80h–8Fh. For each access it decides whether the bank answers, whether the access must also go out to the ISA bus, or both. The upper half of the window, 90h–9Fh, can shadow the bank. Whether it does depends on a control input, the access direction and the address. The parameter `FULL_RANGE` selects one of two variants. In one, setting the control input releases only a fixed set of addresses to the ISA bus. In the other, it releases the whole upper half.

Accesses can come from the CPU or from an ISA bus master. When the alias is switched off, ISA-master accesses to the upper half are dropped. Those accesses also lose the right to restart a small power-management fast-off countdown timer. Every other access inside the window restarts it. The timer is part of the block. It counts down on a tick input from a start value given on a port, and it flags expiry when it reaches zero.

Top module: `pagereg_alias_decoder`

## Requirements
- R1: A CPU access to 80h–8Fh selects page register `addr[3:0]`. A write stores `io_wdata` and is also forwarded to ISA. A read returns the stored byte on `rdata` in the same cycle and is not forwarded.
- R2: With `alias_ctl`=0, a CPU access to 90h–9Fh other than 92h selects the page register at the address minus 10h. A write stores and is forwarded. A read returns the stored byte and is not forwarded.
- R3: A CPU access to 92h is forwarded to ISA in both directions and never selects a page register, whatever `alias_ctl` is.
- R4: With `FULL_RANGE`=0 and `alias_ctl`=1, CPU accesses to 90h–9Fh at low-nibble offsets 0, 4, 5, 6, 8, C, D and E are forwarded in both directions and select nothing. The remaining offsets in that range behave as in R2.
- R5: With `FULL_RANGE`=1 and `alias_ctl`=1, every CPU access to 90h–9Fh is forwarded in both directions and selects nothing.
- R6: With `alias_ctl`=1, an ISA-master access (`src_isa`=1) to 90h–9Fh produces no select, no forward and no timer reload.
- R7: An ISA-master access is never forwarded to ISA. It selects the page register exactly where a CPU access would.
- R8: An access whose full address lies outside 80h–9Fh produces no select, no forward and no reload. Non-zero upper address bits count as outside.
- R9: `tmr_reload` pulses in the cycle of any read or write to 80h–8Fh. It also pulses for 90h–9Fh, but only while `alias_ctl`=0.
- R10: After a cycle with `tmr_reload`, `tmr_count` equals `tmr_start`, and reload wins over `tick`. Otherwise each `tick` lowers the count by one until it holds at zero. `tmr_expired` is 1 exactly when the count is zero.
- R11: After reset, all page registers read 0, `tmr_count` is 0 and `tmr_expired` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe (takes the direction if both are high) |
| io_wdata | input | 8 | Write data |
| src_isa | input | 1 | 1 = access from an ISA master, 0 = from the CPU |
| alias_ctl | input | 1 | 1 = disable aliasing of the upper half |
| tick | input | 1 | Timer count-down enable |
| tmr_start | input | TMR_W | Timer reload value |
| reg_sel | output | 1 | A page register serves this access |
| reg_idx | output | 4 | Index of the selected page register |
| rdata | output | 8 | Read data of a selected read, else 0 |
| isa_fwd | output | 1 | Forward this access to the ISA bus |
| tmr_reload | output | 1 | Timer restart pulse |
| tmr_count | output | TMR_W | Timer current value |
| tmr_expired | output | 1 | Timer is at zero |

## Verification
The decode results `reg_sel`, `reg_idx`, `isa_fwd`, `tmr_reload` and the read data on `rdata` are combinational. They are due in the cycle the access is presented, so the bench drives each access just after a falling edge and samples one time unit later, before the rising edge. Stored bytes and timer values are registered and appear after the next rising edge. The bench therefore reads back or samples `tmr_count` only after that edge, again from the falling-edge half of the cycle. Both variants are instantiated side by side and swept over every address from 78h to A7h, both directions, both sources and both control settings, against an arithmetic model of the page bank.

// File: rtl/pagealias_pkg.sv
package pagealias_pkg;

  localparam int PA_PAGES = 16;
  localparam int PA_IDX_W = $clog2(PA_PAGES);
  localparam int PA_DATA_W = 8;

  // Upper-half offsets released to ISA in the partial variant (R4)
  localparam logic [PA_PAGES-1:0] PA_EXEMPT_MASK = 16'h7171;

  typedef struct packed {
    logic                sel;
    logic [PA_IDX_W-1:0] idx;
    logic                fwd;
    logic                reload;
    logic                ignored;
  } pa_dec_t;

  function automatic logic pa_is_exempt(input logic [PA_IDX_W-1:0] off);
    return PA_EXEMPT_MASK[off];
  endfunction

  // Alias target: address minus 10h, kept to the bank index width
  function automatic logic [PA_IDX_W-1:0] pa_alias_index(input logic [7:0] low_addr);
    logic [7:0] tgt;
    tgt = low_addr - 8'h10;
    return tgt[PA_IDX_W-1:0];
  endfunction

endpackage

// File: rtl/pa_decode.sv
module pa_decode
  import pagealias_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter bit FULL_RANGE = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              src_isa,
  input  logic              alias_ctl,
  output logic              hit_lo,
  output logic              hit_hi,
  output logic              blocked,
  output pa_dec_t           dec
);

  logic                upper_zero;
  logic                acc;
  logic                is_p92;
  logic                ctl_release;
  logic [PA_IDX_W-1:0] off;

  assign upper_zero = (addr[ADDR_W-1:8] == '0);
  assign hit_lo     = upper_zero && (addr[7:4] == 4'h8);
  assign hit_hi     = upper_zero && (addr[7:4] == 4'h9);
  assign off        = addr[PA_IDX_W-1:0];
  assign is_p92     = hit_hi && (off == 4'h2);
  assign acc        = rd | wr;

  generate
    if (FULL_RANGE) begin : g_full
      assign ctl_release = alias_ctl;
    end else begin : g_partial
      assign ctl_release = alias_ctl && pa_is_exempt(off);
    end
  endgenerate

  assign blocked = hit_hi && (is_p92 || ctl_release);

  always_comb begin
    dec.ignored = src_isa && alias_ctl && hit_hi;
    dec.sel     = acc && (hit_lo || (hit_hi && !blocked)) && !dec.ignored;
    dec.idx     = hit_hi ? pa_alias_index(addr[7:0]) : off;
    dec.fwd     = acc && !src_isa &&
                  ((hit_lo && wr) || (hit_hi && (blocked || wr)));
    dec.reload  = acc && (hit_lo || (hit_hi && !alias_ctl));
  end

endmodule

// File: rtl/pa_page_file.sv
module pa_page_file
  import pagealias_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [PA_IDX_W-1:0]  idx,
  input  logic [PA_DATA_W-1:0] wdata,
  output logic [PA_DATA_W-1:0] rdata
);

  logic [PA_DATA_W-1:0] pages [PA_PAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PA_PAGES; i++) pages[i] <= '0;
    end else if (we) begin
      pages[idx] <= wdata;
    end
  end

  assign rdata = pages[idx];

endmodule

// File: rtl/pa_fastoff_timer.sv
module pa_fastoff_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [TMR_W-1:0] start,
  input  logic             tick,
  output logic [TMR_W-1:0] count,
  output logic             expired
);

  function automatic logic [TMR_W-1:0] step_down(input logic [TMR_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (reload) count <= start;
    else if (tick)   count <= step_down(count);
  end

  assign expired = (count == '0);

endmodule

// File: rtl/pagereg_alias_decoder.sv
module pagereg_alias_decoder
  import pagealias_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int TMR_W      = 8,
  parameter bit FULL_RANGE = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic                io_rd,
  input  logic                io_wr,
  input  logic [7:0]          io_wdata,
  input  logic                src_isa,
  input  logic                alias_ctl,
  input  logic                tick,
  input  logic [TMR_W-1:0]    tmr_start,
  output logic                reg_sel,
  output logic [3:0]          reg_idx,
  output logic [7:0]          rdata,
  output logic                isa_fwd,
  output logic                tmr_reload,
  output logic [TMR_W-1:0]    tmr_count,
  output logic                tmr_expired
);

  pa_dec_t             dec;
  logic                hit_lo;
  logic                hit_hi;
  logic                blocked;
  logic                page_we;
  logic                page_rd;
  logic [PA_DATA_W-1:0] page_q;

  pa_decode #(.ADDR_W(ADDR_W), .FULL_RANGE(FULL_RANGE)) u_dec (
    .addr      (io_addr),
    .rd        (io_rd),
    .wr        (io_wr),
    .src_isa   (src_isa),
    .alias_ctl (alias_ctl),
    .hit_lo    (hit_lo),
    .hit_hi    (hit_hi),
    .blocked   (blocked),
    .dec       (dec)
  );

  assign page_we = dec.sel && io_wr;
  assign page_rd = dec.sel && !io_wr;

  pa_page_file u_pages (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (page_we),
    .idx   (dec.idx),
    .wdata (io_wdata),
    .rdata (page_q)
  );

  pa_fastoff_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (dec.reload),
    .start   (tmr_start),
    .tick    (tick),
    .count   (tmr_count),
    .expired (tmr_expired)
  );

  assign reg_sel    = dec.sel;
  assign reg_idx    = dec.idx;
  assign rdata      = page_rd ? page_q : '0;
  assign isa_fwd    = dec.fwd;
  assign tmr_reload = dec.reload;

endmodule

// File: rtl/pa_alias_checker.sv
module pa_alias_checker #(
  parameter int ADDR_W = 16,
  parameter int TMR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic              src_isa,
  input logic              alias_ctl,
  input logic              tick,
  input logic [TMR_W-1:0]  tmr_start,
  input logic              hit_lo,
  input logic              hit_hi,
  input logic              reg_sel,
  input logic              isa_fwd,
  input logic              tmr_reload,
  input logic [TMR_W-1:0]  tmr_count
);

  logic acc;
  assign acc = io_rd | io_wr;

  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_lo && !hit_hi) |-> (!reg_sel && !isa_fwd && !tmr_reload)); // R8

  AST_P92_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !src_isa && io_addr == ADDR_W'(16'h0092)) |-> (isa_fwd && !reg_sel)); // R3

  AST_ISA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (src_isa && alias_ctl && hit_hi) |-> (!reg_sel && !isa_fwd && !tmr_reload)); // R6

  AST_ISA_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    src_isa |-> !isa_fwd); // R7

  AST_ALIAS_READ_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && !src_isa && !alias_ctl && hit_hi &&
     io_addr[3:0] != 4'h2) |-> (reg_sel && !isa_fwd)); // R2

  AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_reload |=> (tmr_count == $past(tmr_start))); // R10

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_reload && tick && tmr_count != '0) |=> (tmr_count == $past(tmr_count) - 1'b1)); // R10

  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_reload && tmr_count == '0) |=> (tmr_count == '0)); // R10

endmodule

bind pagereg_alias_decoder pa_alias_checker #(.ADDR_W(ADDR_W), .TMR_W(TMR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_addr    (io_addr),
  .io_rd      (io_rd),
  .io_wr      (io_wr),
  .src_isa    (src_isa),
  .alias_ctl  (alias_ctl),
  .tick       (tick),
  .tmr_start  (tmr_start),
  .hit_lo     (hit_lo),
  .hit_hi     (hit_hi),
  .reg_sel    (reg_sel),
  .isa_fwd    (isa_fwd),
  .tmr_reload (tmr_reload),
  .tmr_count  (tmr_count)
);

// File: tb/tb_pagereg_alias_decoder.sv
`timescale 1ns/1ps
module tb_pagereg_alias_decoder;

  localparam int AW = 16;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] io_addr = '0;
  logic          io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]    io_wdata = '0;
  logic          src_isa = 1'b0, alias_ctl = 1'b0, tick = 1'b0;
  logic [TW-1:0] tmr_start = '0;

  logic          p_sel, f_sel, p_fwd, f_fwd, p_rl, f_rl, p_exp, f_exp;
  logic [3:0]    p_idx, f_idx;
  logic [7:0]    p_rd, f_rd;
  logic [TW-1:0] p_cnt, f_cnt;

  int errors = 0;
  int checks = 0;
  logic [7:0] mem_p [16];
  logic [7:0] mem_f [16];

  always #2 clk = ~clk;

  pagereg_alias_decoder #(.ADDR_W(AW), .TMR_W(TW), .FULL_RANGE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .src_isa(src_isa), .alias_ctl(alias_ctl), .tick(tick),
    .tmr_start(tmr_start), .reg_sel(p_sel), .reg_idx(p_idx), .rdata(p_rd),
    .isa_fwd(p_fwd), .tmr_reload(p_rl), .tmr_count(p_cnt), .tmr_expired(p_exp));

  pagereg_alias_decoder #(.ADDR_W(AW), .TMR_W(TW), .FULL_RANGE(1'b1)) dut_full (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .src_isa(src_isa), .alias_ctl(alias_ctl), .tick(tick),
    .tmr_start(tmr_start), .reg_sel(f_sel), .reg_idx(f_idx), .rdata(f_rd),
    .isa_fwd(f_fwd), .tmr_reload(f_rl), .tmr_count(f_cnt), .tmr_expired(f_exp));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected outcome: {sel, fwd, reload} and target index
  function automatic logic [2:0] model(input logic [AW-1:0] a, input bit wr,
                                       input bit isa, input bit ctl, input bit full);
    bit lo, hi, rel, drop, sel, fwd, rl;
    int ofs;
    lo   = (a >= 16'h0080) && (a < 16'h0090);
    hi   = (a >= 16'h0090) && (a < 16'h00A0);
    ofs  = int'(a) % 16;
    rel  = hi && ((a == 16'h0092) || (ctl && (full || ofs inside {0, 4, 5, 6, 8, 12, 13, 14})));
    drop = isa && ctl && hi;
    sel  = (lo || (hi && !rel)) && !drop;
    fwd  = !isa && ((lo && wr) || (hi && (rel || wr)));
    rl   = lo || (hi && !ctl);
    return {sel, fwd, rl};
  endfunction

  task automatic one_access(input logic [AW-1:0] a, input bit wr, input bit isa,
                            input bit ctl, input logic [7:0] d);
    logic [2:0] ep, ef;
    int ix;
    @(negedge clk);
    io_addr = a; io_wr = wr; io_rd = !wr; src_isa = isa; alias_ctl = ctl; io_wdata = d;
    #1;
    ep = model(a, wr, isa, ctl, 1'b0);
    ef = model(a, wr, isa, ctl, 1'b1);
    ix = int'(a) % 16;
    // R1 R2 R3 R4 R5 R6 R7 R8: select / forward
    check(p_sel == ep[2], "R4 partial sel", p_sel, ep[2]);
    check(f_sel == ef[2], "R5 full sel", f_sel, ef[2]);
    check(p_fwd == ep[1], "R4 partial fwd", p_fwd, ep[1]);
    check(f_fwd == ef[1], "R5 full fwd", f_fwd, ef[1]);
    // R9 reload pulse
    check(p_rl == ep[0], "R9 partial reload", p_rl, ep[0]);
    check(f_rl == ef[0], "R9 full reload", f_rl, ef[0]);
    if (ep[2]) check(p_idx == 4'(ix), "R2 index", p_idx, ix);
    if (ef[2]) check(f_idx == 4'(ix), "R2 index full", f_idx, ix);
    // R1 R2 read data
    check(p_rd == ((ep[2] && !wr) ? mem_p[ix] : 8'h00), "R1 rdata", p_rd,
          (ep[2] && !wr) ? mem_p[ix] : 8'h00);
    check(f_rd == ((ef[2] && !wr) ? mem_f[ix] : 8'h00), "R1 rdata full", f_rd,
          (ef[2] && !wr) ? mem_f[ix] : 8'h00);
    @(posedge clk);
    if (ep[2] && wr) mem_p[ix] = d;
    if (ef[2] && wr) mem_f[ix] = d;
  endtask

  task automatic idle();
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0; tick = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mem_p[i] = 8'h00; mem_f[i] = 8'h00; end
    tmr_start = 8'd5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    check(p_cnt == 0, "R11 count", p_cnt, 0);
    check(p_exp == 1'b1, "R11 expired", p_exp, 1);
    check(f_exp == 1'b1, "R11 expired full", f_exp, 1);
    for (int a = 16'h80; a < 16'h90; a++) one_access(AW'(a), 1'b0, 1'b0, 1'b0, 8'h00);

    // Sweep: ctl, source, direction, address
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 2; s++)
        for (int w = 1; w >= 0; w--)
          for (int a = 16'h78; a < 16'hA8; a++)
            one_access(AW'(a), w[0], s[0], c[0], 8'(a * 7 + c * 3 + s * 11 + 1));

    // R8 upper address bits set
    one_access(16'h0180, 1'b1, 1'b0, 1'b0, 8'hAA);
    one_access(16'h1095, 1'b0, 1'b0, 1'b0, 8'h00);
    // readback after outside write
    for (int a = 16'h80; a < 16'h90; a++) one_access(AW'(a), 1'b0, 1'b0, 1'b0, 8'h00);

    // R10 timer: reload then count down to zero and hold
    one_access(16'h0083, 1'b0, 1'b0, 1'b0, 8'h00);
    idle();
    #1;
    check(p_cnt == 5, "R10 loaded", p_cnt, 5);
    check(p_exp == 1'b0, "R10 not expired", p_exp, 0);
    for (int k = 4; k >= 0; k--) begin
      tick = 1'b1;
      @(negedge clk);
      #1;
      check(p_cnt == TW'(k), "R10 tick step", p_cnt, k);
    end
    check(p_exp == 1'b1, "R10 expired", p_exp, 1);
    @(negedge clk);
    #1;
    check(p_cnt == 0, "R10 holds zero", p_cnt, 0);
    // reload beats tick
    tmr_start = 8'd9;
    tick = 1'b1;
    one_access(16'h0091, 1'b1, 1'b0, 1'b0, 8'h12);
    idle();
    #1;
    check(p_cnt == 9, "R10 reload over tick", p_cnt, 9);
    check(f_cnt == 9, "R10 reload over tick full", f_cnt, 9);
    // R6/R9: ctl=1 upper-half access leaves timer untouched
    tmr_start = 8'd40;
    one_access(16'h0093, 1'b1, 1'b0, 1'b1, 8'h34);
    one_access(16'h0097, 1'b0, 1'b1, 1'b1, 8'h00);
    idle();
    #1;
    check(p_cnt == 9, "R9 no reload ctl=1", p_cnt, 9);
    check(f_cnt == 9, "R6 no reload ctl=1 full", f_cnt, 9);
    // R2/R4: the aliased write at 93h (partial, ctl=1) landed in page 3
    one_access(16'h0083, 1'b0, 1'b0, 1'b0, 8'h00);
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule